// File: doc/BRIEF.md
# Cascaded Two-Group DMA Request Arbiter

This block picks one winner among eight DMA channels. The channels form two groups of four. The lower group (channels 0 to 3) does not compete directly. It feeds the upper group through slot 4, which acts as a cascade input. When the upper group picks the cascade slot, the grant goes through to whichever lower channel the lower group has selected.

Each group has a command register that software writes. It chooses fixed or rotating priority for the group, and it can switch the group off. Switching off the upper group also shuts out the lower group, because the lower group can only reach the upper one through the cascade slot.

Each group also has a status register that software reads. It shows which channels have a request pending and which have hit terminal count. Reading it clears the terminal-count flags. A channel's request is pending when its hardware request line or its software request bit is high. The grant output is one-hot over the eight channels.

Top module: `dma_cascade_arb`

## Requirements
- R1: After reset, no grant is driven, both groups use fixed priority and both are enabled, and every terminal-count flag reads 0.
- R2: A channel is pending when `hw_req[i] | sw_req[i]` is high. A status read returns the pending state in bits 7:4. For the lower group, bit 4+k is channel k. For the upper group, bit 4+k is channel 4+k.
- R3: In the upper group's status, bit 4 reads as the OR of the raw pending state of channels 0 to 3, and bit 0 (the terminal-count bit of the cascade slot) always reads 0.
- R4: In fixed priority (command bit 4 = 0), the lowest-numbered requesting slot in a group wins. In the upper group, slot 4 (the cascade) outranks channels 5 to 7.
- R5: In rotating priority (command bit 4 = 1), the slot granted last in a group becomes that group's lowest priority, and the slot just above it becomes the highest.
- R6: A grant appears one clock after the request that wins it. It stays on that channel while the channel's request stays high. When the request drops, arbitration runs again at that same edge. `grant` is one-hot or zero, and `grant[4]` is never set.
- R7: Command bit 2 = 1 disables a group. A disabled group grants nothing and, for the lower group, forwards no request into the cascade slot. Its status still shows pending requests.
- R8: Disabling the upper group also removes every grant to channels 0 to 3. A grant is 0 in the cycle after that write.
- R9: A terminal-count pulse sets the channel's flag at the next edge. The flag stays set until a status read of its group clears it.
  - Read data appears on `reg_rdata` one clock after the `reg_rd` strobe (`reg_grp` = 0 selects the lower group, 1 the upper).
  - The flags occupy status bits 3:0 in ascending channel order.
  - When a pulse and a read of the same group coincide, the read returns the old value and the flag stays set.
- R10: Command bits 7:5, 3 and 1:0 are ignored on write.
- R11: A lower channel's grant reaches `grant[3:0]` only while the upper group grants its cascade slot.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 8 | Hardware request level per channel |
| sw_req | input | 8 | Software request level per channel |
| tc_pulse | input | 8 | Terminal-count pulse per channel |
| reg_wr | input | 1 | Command write strobe |
| reg_rd | input | 1 | Status read strobe |
| reg_grp | input | 1 | Group select: 0 lower, 1 upper |
| reg_wdata | input | 8 | Command write data |
| reg_rdata | output | 8 | Registered status read data |
| grant | output | 8 | One-hot channel grant |

## Verification
The hold assertion assumes no command write happens while a grant is held, so it exempts write cycles. The terminal-count assertion assumes a status read comes in the cycle right after the pulse. The bench changes the command registers only while all requests are low, except where a disable is under test. It holds every request as a level for whole cycles and raises each terminal-count pulse for exactly one cycle. It always writes the reserved command bits as zero, except in the single case that tests that they are ignored.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // Channels per group; must be a power of two so the rotation index wraps.
    localparam int GRP_CH  = 4;
    localparam int IDX_W   = $clog2(GRP_CH);
    localparam int NCH     = 2 * GRP_CH;
    localparam int CMD_W   = 8;
    localparam int STAT_W  = 2 * GRP_CH;
    // Command fields decoded by the group logic.
    localparam int CMD_ROT_BIT = 4;
    localparam int CMD_DIS_BIT = 2;

    typedef struct packed {
        logic              rot;
        logic              dis;
        logic [GRP_CH-1:0] gnt;
        logic [IDX_W-1:0]  last;
        logic [GRP_CH-1:0] tc;
    } grp_state_t;

    // Choose the first requester, scanning upward from the start slot.
    function automatic logic [GRP_CH-1:0] pick_winner(
        input logic [GRP_CH-1:0] req,
        input logic              rot,
        input logic [IDX_W-1:0]  last
    );
        logic [GRP_CH-1:0] win;
        logic              found;
        logic [IDX_W-1:0]  start;
        logic [IDX_W-1:0]  idx;
        win   = '0;
        found = 1'b0;
        start = rot ? IDX_W'(last + 1'b1) : '0;
        for (int k = 0; k < GRP_CH; k++) begin
            idx = IDX_W'(start + IDX_W'(k));
            if (!found && req[idx]) begin
                win[idx] = 1'b1;
                found    = 1'b1;
            end
        end
        return win;
    endfunction

    function automatic logic [IDX_W-1:0] onehot_idx(input logic [GRP_CH-1:0] oh);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int k = 0; k < GRP_CH; k++) begin
            if (oh[k]) r = IDX_W'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/dma_arb_grp.sv
module dma_arb_grp
    import dma_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              parent_en_i,
    input  logic [GRP_CH-1:0] pend_i,
    input  logic [GRP_CH-1:0] req_i,
    input  logic [GRP_CH-1:0] tc_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              cmd_rot_i,
    input  logic              cmd_dis_i,
    output logic [GRP_CH-1:0] gnt_o,
    output logic              fwd_req_o,
    output logic              en_o,
    output logic [STAT_W-1:0] status_o
);

    grp_state_t st_d, st_q;
    logic       en_next;
    logic [GRP_CH-1:0] live;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.rot = cmd_rot_i;
            st_d.dis = cmd_dis_i;
        end
        en_next = !st_d.dis && parent_en_i;
        live    = st_q.gnt & req_i;
        if (!en_next) begin
            st_d.gnt = '0;
        end else if (|live) begin
            st_d.gnt = st_q.gnt;
        end else begin
            st_d.gnt = pick_winner(req_i, st_d.rot, st_q.last);
            if (|st_d.gnt) st_d.last = onehot_idx(st_d.gnt);
        end
        if (rd_i) st_d.tc = '0;
        st_d.tc = st_d.tc | tc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rot  <= 1'b0;
            st_q.dis  <= 1'b0;
            st_q.gnt  <= '0;
            st_q.last <= IDX_W'(GRP_CH - 1);
            st_q.tc   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o      = !st_q.dis && parent_en_i;
    assign fwd_req_o = en_o && (|req_i);
    assign gnt_o     = st_q.gnt;
    assign status_o  = {pend_i, st_q.tc};

endmodule

// File: rtl/dma_cascade_arb.sv
module dma_cascade_arb
    import dma_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   hw_req,
    input  logic [NCH-1:0]   sw_req,
    input  logic [NCH-1:0]   tc_pulse,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_grp,
    input  logic [CMD_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic [NCH-1:0]   grant
);

    typedef struct packed {
        logic [STAT_W-1:0] rdata;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [NCH-1:0]    pend;
    logic [GRP_CH-1:0] lo_gnt, up_gnt;
    logic              lo_fwd, up_fwd, lo_en, up_en;
    logic [STAT_W-1:0] lo_stat, up_stat;
    logic              unused_bits;

    assign pend = hw_req | sw_req;
    assign unused_bits = ^{reg_wdata[CMD_W-1:CMD_ROT_BIT+1],
                           reg_wdata[CMD_ROT_BIT-1:CMD_DIS_BIT+1],
                           reg_wdata[CMD_DIS_BIT-1:0], up_fwd, lo_en, tc_pulse[GRP_CH]};

    dma_arb_grp u_lo (
        .clk(clk), .rst_n(rst_n),
        .parent_en_i(up_en),
        .pend_i(pend[GRP_CH-1:0]),
        .req_i(pend[GRP_CH-1:0]),
        .tc_i(tc_pulse[GRP_CH-1:0]),
        .wr_i(reg_wr && !reg_grp),
        .rd_i(reg_rd && !reg_grp),
        .cmd_rot_i(reg_wdata[CMD_ROT_BIT]),
        .cmd_dis_i(reg_wdata[CMD_DIS_BIT]),
        .gnt_o(lo_gnt), .fwd_req_o(lo_fwd), .en_o(lo_en),
        .status_o(lo_stat)
    );

    dma_arb_grp u_up (
        .clk(clk), .rst_n(rst_n),
        .parent_en_i(1'b1),
        .pend_i({pend[NCH-1:GRP_CH+1], |pend[GRP_CH-1:0]}),
        .req_i({pend[NCH-1:GRP_CH+1], lo_fwd}),
        .tc_i({tc_pulse[NCH-1:GRP_CH+1], 1'b0}),
        .wr_i(reg_wr && reg_grp),
        .rd_i(reg_rd && reg_grp),
        .cmd_rot_i(reg_wdata[CMD_ROT_BIT]),
        .cmd_dis_i(reg_wdata[CMD_DIS_BIT]),
        .gnt_o(up_gnt), .fwd_req_o(up_fwd), .en_o(up_en),
        .status_o(up_stat)
    );

    always_comb begin
        top_d = top_q;
        if (reg_rd) top_d.rdata = reg_grp ? up_stat : lo_stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign reg_rdata = top_q.rdata;
    assign grant = {up_gnt[GRP_CH-1:1], 1'b0, lo_gnt & {GRP_CH{up_gnt[0]}}};

endmodule

// File: rtl/dma_cascade_arb_chk.sv
module dma_cascade_arb_chk
    import dma_arb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    hw_req,
    input logic [NCH-1:0]    sw_req,
    input logic              tc1,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              reg_grp,
    input logic              wdata_dis,
    input logic [STAT_W-1:0] reg_rdata,
    input logic [NCH-1:0]    grant
);

    logic [NCH-1:0] pend;
    assign pend = hw_req | sw_req;

    assert_gnt_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && !grant[GRP_CH]);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assert_gnt_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> $past(pend[i]));
        assert_gnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] && pend[i] && !reg_wr |=> grant[i]);
    end

    assert_up_dis_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_grp && wdata_dis |=> grant == '0);

    assert_stat_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && !reg_grp |=> reg_rdata[STAT_W-1:GRP_CH] == $past(pend[GRP_CH-1:0]));

    assert_cascade_stat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_grp |=> !reg_rdata[0] && (reg_rdata[GRP_CH] == $past(|pend[GRP_CH-1:0])));

    assert_tc_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tc1 ##1 (reg_rd && !reg_grp) |=> reg_rdata[1]);

endmodule

bind dma_cascade_arb dma_cascade_arb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_req(sw_req),
    .tc1(tc_pulse[1]), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_grp(reg_grp),
    .wdata_dis(reg_wdata[dma_arb_pkg::CMD_DIS_BIT]),
    .reg_rdata(reg_rdata), .grant(grant)
);

// File: tb/dma_cascade_arb_tb_top.sv
`timescale 1ns/1ps
module dma_cascade_arb_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hw_req = '0, sw_req = '0, tc_pulse = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_grp = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, grant;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        string      tag;
        logic [7:0] exp_gnt;
        bit         chk_rd;
        logic [7:0] exp_rd;
    } item_t;

    item_t exp_q[$];

    always #2 clk = ~clk;

    dma_cascade_arb dut_i (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_req(sw_req),
        .tc_pulse(tc_pulse), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_grp(reg_grp), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .grant(grant)
    );

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_run++;
            if (grant !== it.exp_gnt) begin
                n_fail++;
                $display("FAIL %s: grant=%h expected %h", it.tag, grant, it.exp_gnt);
            end
            if (it.chk_rd) begin
                n_run++;
                if (reg_rdata !== it.exp_rd) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h expected %h", it.tag, reg_rdata, it.exp_rd);
                end
            end
        end
    end

    // Driver: one clock step, then queue what the ports must show after it.
    task automatic cyc(input string tag, input logic [7:0] eg,
                       input bit crd, input logic [7:0] erd);
        @(posedge clk);
        exp_q.push_back('{tag, eg, crd, erd});
        @(negedge clk);
        #1;
    endtask

    task automatic wr_cmd(input bit grp, input logic [7:0] val, input string tag);
        reg_wr = 1'b1; reg_grp = grp; reg_wdata = val;
        cyc(tag, 8'h00, 1'b0, 8'h00);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_set(input bit grp);
        reg_rd = 1'b1; reg_grp = grp;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;

        rd_set(0); cyc("R1 reset state", 8'h00, 1, 8'h00); reg_rd = 0;

        // Fixed priority in the lower group, status order.
        hw_req = 8'h06; rd_set(0);
        cyc("R2 R4 R11 lower fixed", 8'h02, 1, 8'h60); reg_rd = 0;
        hw_req = 8'h04; cyc("R6 regrant on drop", 8'h04, 0, 0);
        hw_req = 8'h05; cyc("R6 hold while requested", 8'h04, 0, 0);
        hw_req = 8'h00; cyc("R6 release", 8'h00, 0, 0);

        // Upper group, software request.
        hw_req = 8'h20; sw_req = 8'h40; rd_set(1);
        cyc("R2 R4 upper fixed", 8'h20, 1, 8'h60); reg_rd = 0;
        hw_req = 0; sw_req = 0; cyc("R6 release upper", 8'h00, 0, 0);

        // Cascade outranks 5..7 in fixed mode.
        hw_req = 8'h88; rd_set(1);
        cyc("R3 R4 R11 cascade wins", 8'h08, 1, 8'h90); reg_rd = 0;
        hw_req = 0; cyc("R11 release", 8'h00, 0, 0);

        // Rotating priority in the lower group.
        wr_cmd(0, 8'h10, "R5 write rotate");
        hw_req = 8'h0D; cyc("R5 first pick", 8'h01, 0, 0);
        hw_req = 8'h0C; cyc("R5 next above", 8'h04, 0, 0);
        hw_req = 8'h09; cyc("R5 rotated past ch0", 8'h08, 0, 0);
        hw_req = 0; cyc("R5 release", 8'h00, 0, 0);
        wr_cmd(0, 8'h00, "R5 back to fixed");

        // Reserved command bits ignored: upper stays fixed.
        wr_cmd(1, 8'hEB, "R10 reserved write");
        hw_req = 8'hE0; cyc("R10 fixed ch5", 8'h20, 0, 0);
        hw_req = 8'hC0; cyc("R10 ch6", 8'h40, 0, 0);
        hw_req = 8'hA0; cyc("R10 still fixed", 8'h20, 0, 0);
        hw_req = 0; cyc("R10 release", 8'h00, 0, 0);

        // Lower group disabled.
        wr_cmd(0, 8'h04, "R7 disable lower");
        hw_req = 8'h42; rd_set(0);
        cyc("R7 lower silent", 8'h40, 1, 8'h20);
        rd_set(1); cyc("R7 R3 raw cascade pend", 8'h40, 1, 8'h50); reg_rd = 0;
        hw_req = 0; cyc("R7 release", 8'h00, 0, 0);
        wr_cmd(0, 8'h00, "R7 enable lower");

        // Upper group disabled.
        wr_cmd(1, 8'h04, "R8 disable upper");
        hw_req = 8'h21; rd_set(0);
        cyc("R8 no grant", 8'h00, 1, 8'h10); reg_rd = 0;
        hw_req = 0; cyc("R8 idle", 8'h00, 0, 0);
        wr_cmd(1, 8'h00, "R8 enable upper");
        hw_req = 8'h01; cyc("R8 lower back", 8'h01, 0, 0);
        hw_req = 0; cyc("R8 release", 8'h00, 0, 0);

        // Terminal-count flags.
        tc_pulse = 8'h44; cyc("R9 pulse", 8'h00, 0, 0); tc_pulse = 0;
        rd_set(0); cyc("R9 lower flag", 8'h00, 1, 8'h04);
        rd_set(1); cyc("R9 upper flag", 8'h00, 1, 8'h04);
        rd_set(0); cyc("R9 cleared by read", 8'h00, 1, 8'h00);
        tc_pulse = 8'h08; cyc("R9 coincident read", 8'h00, 1, 8'h00);
        tc_pulse = 0; cyc("R9 set wins", 8'h00, 1, 8'h08);
        reg_rd = 0;
        tc_pulse = 8'h10; cyc("R3 cascade tc pulse", 8'h00, 0, 0); tc_pulse = 0;
        rd_set(1); cyc("R3 cascade tc reads 0", 8'h00, 1, 8'h00); reg_rd = 0;

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule